// File: doc/BRIEF.md
# Zero Run-Length Encoder

This block shortens a stream of signed, quantized transform coefficients in which zeros are common. Every nonzero word goes through unchanged. A run of consecutive zeros, however long, becomes two words: a zero word that marks the start of a run, then a word that holds the number of zeros in the run. A downstream decoder reads any zero word as "a count follows". Isolated zeros therefore cost two words each, and data that has many lone zeros grows instead of shrinking.

Both sides use a valid/ready stream. A word moves when valid and ready are high on the same rising edge. The input also carries an end-of-block flag. The marker word goes out when the first zero of a run is accepted. The count word goes out when the run ends, either because a nonzero word arrives or because the end-of-block flag arrives. The end-of-block flag is carried on the final output word of the block. The output is held in a register. While `out_valid` is high and `out_ready` is low, that word stays unchanged, and `in_ready` drops as long as the register cannot drain.

Top module: `zrle_encoder`

## Requirements
- R1: A nonzero input word appears unchanged on `out_data`, in input order. When no run is pending, it appears on the cycle after it is accepted.
- R2: When a zero is accepted and no run is pending, a marker word of value 0 is presented on the next cycle.
- R3: A maximal run of consecutive zeros gives exactly one marker/count pair. The count word is the number of zeros in the run, as an unsigned value in the low bits of the word. Decoding each pair back into zeros rebuilds the input exactly.
- R4: A single zero between nonzero words gives the two words 0, 1.
- R5: An end-of-block flag on an input word closes any pending run within that block. `out_last` is 1 on the final output word of the block and 0 on every other word.
- R6: The run count saturates at MAX_RUN (default 64). A run of 70 zeros gives a count word of 64, and the count never wraps to a small value.
- R7: With `out_ready` held high, accepting a nonzero word that ends a run makes `in_ready` low for exactly one cycle. The word is then sent after the count.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Encoder accepts the offered word |
| in_data | input | W | Signed coefficient, two's complement |
| in_last | input | 1 | Word is the last of its block |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | W | Coefficient, run marker or run count |
| out_last | output | 1 | Final output word of a block |

## Verification
Two events can fall on the same accepted word: the end-of-block flush and the close of a zero run. This happens when a block ends in a zero, either one that extends a run or one that starts a run by itself. The bench uses table blocks that end in long runs, in a single zero and in all zeros. It also uses random sparse blocks, with the output stalled at random. It checks that the count word is right, that `out_last` sits only on the last word, and that the words decode back to the input.

// File: rtl/zrle_pkg.sv
package zrle_pkg;
  typedef enum logic [1:0] {
    PH_NORM  = 2'd0,
    PH_COUNT = 2'd1,
    PH_HOLD  = 2'd2
  } phase_t;
endpackage

// File: rtl/zrle_run_ctr.sv
module zrle_run_ctr #(
  parameter int MAX_RUN = 64,
  localparam int CW = $clog2(MAX_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_one,
  input  logic          bump,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next
);
  localparam logic [CW-1:0] CAP = CW'(MAX_RUN);

  // saturating successor of the present count
  assign cnt_next = (cnt >= CAP) ? CAP : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load_one) cnt <= CW'(1);
    else if (bump)     cnt <= cnt_next;
  end

  a_r6_cap : assert property (@(posedge clk) disable iff (!rst_n) cnt <= CAP);
  a_r6_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    bump && !load_one |=> cnt >= $past(cnt));
endmodule

// File: rtl/zrle_out_stage.sv
module zrle_out_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         push_last,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (slot_free) begin
      out_valid <= push;
      if (push) begin
        out_data <= push_data;
        out_last <= push_last;
      end
    end
  end

  a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  a_r8_no_overrun : assert property (@(posedge clk) disable iff (!rst_n)
    push |-> slot_free);
endmodule

// File: rtl/zrle_encoder.sv
module zrle_encoder
  import zrle_pkg::*;
#(
  parameter int W       = 12,
  parameter int MAX_RUN = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_last
);
  localparam int CW = $clog2(MAX_RUN + 1);

  phase_t        ph, ph_n;
  logic          active, act_n;
  logic [W-1:0]  hold_data;
  logic          hold_last, hold_ld;
  logic          slot_free, acc, is_zero;
  logic          emit, emit_last, ld_one, bump;
  logic [W-1:0]  emit_data;
  logic [CW-1:0] cnt, cnt_next;

  function automatic logic [W-1:0] cword(input logic [CW-1:0] c);
    return {{(W-CW){1'b0}}, c};
  endfunction

  assign in_ready = (ph == PH_NORM) && slot_free;
  assign acc      = in_valid && in_ready;
  assign is_zero  = (in_data == '0);

  always_comb begin
    emit      = 1'b0;
    emit_data = '0;
    emit_last = 1'b0;
    ph_n      = ph;
    act_n     = active;
    hold_ld   = 1'b0;
    ld_one    = 1'b0;
    bump      = 1'b0;
    case (ph)
      PH_NORM: if (acc) begin
        if (is_zero) begin
          if (!active) begin
            emit   = 1'b1;               // run marker
            ld_one = 1'b1;
            act_n  = 1'b1;
            if (in_last) ph_n = PH_COUNT;
          end else if (in_last) begin
            emit      = 1'b1;            // run closed by block end
            emit_data = cword(cnt_next);
            emit_last = 1'b1;
            act_n     = 1'b0;
          end else begin
            bump = 1'b1;
          end
        end else if (active) begin
          emit      = 1'b1;              // count now, nonzero word next
          emit_data = cword(cnt);
          hold_ld   = 1'b1;
          act_n     = 1'b0;
          ph_n      = PH_HOLD;
        end else begin
          emit      = 1'b1;
          emit_data = in_data;
          emit_last = in_last;
        end
      end
      PH_COUNT: if (slot_free) begin
        emit      = 1'b1;
        emit_data = cword(cnt);
        emit_last = 1'b1;
        act_n     = 1'b0;
        ph_n      = PH_NORM;
      end
      PH_HOLD: if (slot_free) begin
        emit      = 1'b1;
        emit_data = hold_data;
        emit_last = hold_last;
        ph_n      = PH_NORM;
      end
      default: ph_n = PH_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_NORM;
      active    <= 1'b0;
      hold_data <= '0;
      hold_last <= 1'b0;
    end else begin
      ph     <= ph_n;
      active <= act_n;
      if (hold_ld) begin
        hold_data <= in_data;
        hold_last <= in_last;
      end
    end
  end

  zrle_run_ctr #(.MAX_RUN(MAX_RUN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load_one(ld_one), .bump(bump),
    .cnt(cnt), .cnt_next(cnt_next)
  );

  zrle_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .push(emit), .push_data(emit_data),
    .push_last(emit_last), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .slot_free(slot_free)
  );

  a_r1_pass : assert property (@(posedge clk) disable iff (!rst_n)
    acc && !is_zero && !active |=>
      out_valid && out_data == $past(in_data) && out_last == $past(in_last));
  a_r2_marker : assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_zero && !active |=> out_valid && out_data == '0 && !out_last);
  a_r7_one_stall : assert property (@(posedge clk) disable iff (!rst_n)
    acc && !is_zero && active |=> !in_ready);
  a_r5_flush_last : assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_COUNT) && slot_free |=> out_valid && out_last);
endmodule

// File: tb/zrle_encoder_test.sv
`timescale 1ns/1ps
module zrle_encoder_test;
  localparam int W = 12;
  localparam int MAXR = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [W-1:0] out_data;

  zrle_encoder #(.W(W), .MAX_RUN(MAXR)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always #2.5 clk = ~clk;

  // stimulus table: 8 blocks of 8 words, the last word of each carries end-of-block
  localparam logic signed [W-1:0] VEC [0:7][0:7] = '{
    '{12'sd5, -12'sd3, 12'sd7, 12'sd1, -12'sd1, 12'sd2, 12'sd9, 12'sd4},
    '{12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0},
    '{12'sd3, 12'sd0, 12'sd4, 12'sd0, 12'sd5, 12'sd0, 12'sd6, 12'sd0},
    '{12'sd0, 12'sd0, 12'sd0, 12'sd8, -12'sd8, 12'sd0, 12'sd0, 12'sd1},
    '{12'sd9, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0},
    '{12'sd0, 12'sd2, 12'sd0, 12'sd0, 12'sd3, 12'sd0, 12'sd0, 12'sd0},
    '{-12'sd2047, 12'sd2047, 12'sd0, -12'sd1, 12'sd0, 12'sd0, 12'sd1, 12'sd0},
    '{12'sd1, 12'sd1, 12'sd1, 12'sd1, 12'sd1, 12'sd1, 12'sd1, 12'sd0}
  };

  int n_chk = 0, n_bad = 0, cyc = 0;
  int got_d[$];
  int got_l[$];
  int bp_mode = 0;
  bit prev_stall = 0;
  int prev_d = 0, prev_l = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // output side: ready pattern and word capture, evaluated at the falling edge
  always @(negedge clk) begin
    if (prev_stall)
      chk(out_valid && $signed(out_data) == prev_d && out_last == prev_l[0],
          "R8 hold", $signed(out_data), prev_d);
    out_ready = (bp_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
    if (out_valid && out_ready) begin
      got_d.push_back($signed(out_data));
      got_l.push_back(int'(out_last));
    end
    prev_stall = out_valid && !out_ready;
    prev_d = $signed(out_data);
    prev_l = int'(out_last);
  end

  task automatic send_word(input int v, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = W'(v); in_last = last;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
  endtask

  task automatic send_block(input int v[$]);
    foreach (v[i]) send_word(v[i], i == v.size() - 1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // encoding rules written from the requirements
  function automatic void model(input int v[$], output int ed[$], output int el[$]);
    int run = 0;
    bit act = 0;
    ed = {}; el = {};
    foreach (v[i]) begin
      if (v[i] == 0) begin
        if (!act) begin ed.push_back(0); act = 1; run = 1; end
        else if (run < MAXR) run++;
      end else begin
        if (act) begin ed.push_back(run); act = 0; end
        ed.push_back(v[i]);
      end
    end
    if (act) ed.push_back(run);
    foreach (ed[i]) el.push_back(i == ed.size() - 1);
  endfunction

  task automatic drain(input int n);
    for (int k = 0; k < 3000 && got_d.size() < n; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_block(input int v[$], input string req, input bit trip);
    int ed[$];
    int el[$];
    int dec[$];
    model(v, ed, el);
    got_d = {}; got_l = {};
    send_block(v);
    drain(ed.size());
    chk(got_d.size() == ed.size(), {req, " R3 length"}, got_d.size(), ed.size());
    foreach (ed[i]) if (i < got_d.size()) begin
      chk(got_d[i] == ed[i], {req, " R1 word"}, got_d[i], ed[i]);
      chk(got_l[i] == el[i], {req, " R5 last"}, got_l[i], el[i]);
    end
    if (trip) begin
      for (int i = 0; i < got_d.size(); i++) begin
        if (got_d[i] == 0 && i + 1 < got_d.size()) begin
          for (int z = 0; z < got_d[i+1]; z++) dec.push_back(0);
          i++;
        end else dec.push_back(got_d[i]);
      end
      chk(dec == v, {req, " R3 round trip"}, dec.size(), v.size());
    end
  endtask

  initial begin
    int v[$];
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R9 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid, "R9 out_valid after reset", out_valid, 0);
    chk(in_ready, "R9 in_ready after reset", in_ready, 1);

    // table walk, once without and once with back-pressure
    for (int m = 0; m < 2; m++) begin
      bp_mode = m;
      for (int b = 0; b < 8; b++) begin
        v = {};
        for (int k = 0; k < 8; k++) v.push_back(int'(VEC[b][k]));
        run_block(v, "table", 1);
      end
    end

    // R4 lone zero costs two words
    bp_mode = 0;
    run_block('{6, 0, 6}, "R4", 1);
    chk(got_d.size() == 4 && got_d[1] == 0 && got_d[2] == 1, "R4 pair",
        got_d.size(), 4);

    // R7 one stall cycle after a nonzero ends a run
    got_d = {}; got_l = {};
    send_word(0, 0);
    send_word(0, 0);
    send_word(9, 1);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; #1;
    chk(!in_ready, "R7 stall", in_ready, 0);
    @(negedge clk); #1;
    chk(in_ready, "R7 stall ends", in_ready, 1);
    drain(3);
    chk(got_d.size() == 3 && got_d[1] == 2 && got_d[2] == 9, "R7 sequence",
        got_d.size(), 3);

    // R6 saturation: 70 zeros then a nonzero
    v = {};
    for (int k = 0; k < 70; k++) v.push_back(0);
    v.push_back(5);
    run_block(v, "R6", 0);
    chk(got_d.size() == 3 && got_d[1] == MAXR, "R6 saturated count",
        got_d.size() > 1 ? got_d[1] : -1, MAXR);

    // R2 marker appears on the cycle after the first zero
    got_d = {}; got_l = {};
    send_word(0, 1);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; #1;
    chk(out_valid && out_data == '0 && !out_last, "R2 marker", $signed(out_data), 0);
    drain(2);

    // random sparse 64-word blocks
    for (int b = 0; b < 24; b++) begin
      bp_mode = b % 2;
      v = {};
      for (int k = 0; k < 64; k++) begin
        int x;
        x = int'($urandom % 601) - 300;
        if ($urandom % 10 < 7 || x == 0) x = 0;
        v.push_back(x);
      end
      run_block(v, "random", 1);
    end

    summary();
  end
endmodule